// File: doc/BRIEF.md
# Multiply-Result Accumulator with Preload

This stage sits after the multiplier of a fixed-point arithmetic slice. Each cycle it takes a signed product and a 64-bit chain value from the slice before it, and three control bits: negate, load-constant and accumulate. From these bits it forms the next value of a 64-bit result register. The stage can clear the register or add a one-hot rounding constant to the product. It can also keep a running sum or running difference, or subtract the product from the incoming chain value. The registered result also drives the chain output to the next slice.

The rounding constant is given as a bit position and decoded internally, so it always has exactly one bit set. A static dual-mode input turns off all accumulation and chaining, for use when the multiplier is split into two independent small multipliers. In that mode each half of the product input is sign-extended into its own 32-bit lane of the result.

Top module: `mac_accum_stage`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `result_o` and `chain_o` become zero at that edge.
- R2: Control code {neg_i, ldc_i, acc_i} = 000 loads the sign-extended product alone. The old result is discarded.
- R3: Code 010 loads the sign-extended product plus 2^`rnd_pos_i`, where `rnd_pos_i` is a 6-bit bit position from 0 to 63.
- R4: Code 0x1 (ldc_i ignored) loads the previous result plus the sign-extended product.
- R5: Code 1x1 (ldc_i ignored) loads the previous result minus the sign-extended product.
- R6: Code 100 loads `chain_i` minus the sign-extended product.
- R7: Code 110 is not a valid function. It behaves exactly as code 000.
- R8: All arithmetic wraps modulo 2^64 and never saturates.
- R9: With `en_i` low and `clr_i` low the result holds. `clr_i` high loads zero whatever the value of `en_i`.
- R10: With `dual_i` high and the stage enabled, bits [26:0] and [53:27] of `prod_i` are each sign-extended to 32 bits. They are placed in result bits [31:0] and [63:32]. The control bits and `chain_i` have no effect.
- R11: `chain_o` always equals `result_o`. Both change one clock edge after the inputs that produce them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_i | input | 1 | Clock enable for the result register |
| clr_i | input | 1 | Synchronous clear, overrides enable |
| dual_i | input | 1 | Static dual small-multiplier mode, bypasses accumulation |
| neg_i | input | 1 | Negate control bit |
| ldc_i | input | 1 | Load-constant control bit |
| acc_i | input | 1 | Accumulate control bit |
| rnd_pos_i | input | 6 | Bit position of the rounding constant |
| prod_i | input | 54 | Signed product (two 27-bit products in dual mode) |
| chain_i | input | 64 | Chain value from the preceding slice |
| result_o | output | 64 | Registered result |
| chain_o | output | 64 | Chain value to the next slice (equals result_o) |

## Verification
The bench checks a rounding bit at positions 0 and 63 and places one on a negative product. A decoder with an off-by-one error, or one that truncates the constant, would put the bit in the wrong place or lose it. The bench also runs ldc_i up and down during accumulation and decimation. A design that decoded load-constant there would reset the running sum. Wrap-around at the 2^63 boundary in both directions exposes saturation or missing sign extension, and the 110 code exposes a design that accumulates or chains on an undefined code. Dual mode is driven with accumulate set and a live chain input, so any leak of feedback or chain into the lanes shows up as corrupted lane values.

// File: rtl/accum_pkg.sv
// Shared types for the accumulate/chain stage.
// Assumes the control code order {negate, load-constant, accumulate}.
package accum_pkg;

    typedef enum logic [2:0] {
        FN_ZERO    = 3'd0,
        FN_PRELOAD = 3'd1,
        FN_ACC     = 3'd2,
        FN_DECACC  = 3'd3,
        FN_CHAIN   = 3'd4
    } acc_fn_e;

endpackage

// File: rtl/accum_ctrl_decode.sv
// Maps the three dynamic control bits to one stage function.
// Assumes codes that are not listed (only 110 remains) fall back to zeroing.
module accum_ctrl_decode
    import accum_pkg::*;
(
    input  logic    neg_i,
    input  logic    ldc_i,
    input  logic    acc_i,
    output acc_fn_e fn_o
);

    // Priority decode: accumulate dominates, then the negate/constant pair.
    always_comb begin
        if (acc_i)
            fn_o = neg_i ? FN_DECACC : FN_ACC;
        else if (!neg_i && ldc_i)
            fn_o = FN_PRELOAD;
        else if (neg_i && !ldc_i)
            fn_o = FN_CHAIN;
        else
            fn_o = FN_ZERO;
    end

endmodule

// File: rtl/accum_onehot.sv
// Decodes a bit position into a one-hot rounding constant.
// Assumes W is a power of two so every position code is valid.
module accum_onehot #(
    parameter int W     = 64,
    localparam int POSW = $clog2(W)
) (
    input  logic [POSW-1:0] pos_i,
    output logic [W-1:0]    oh_o
);

    // One comparator per result bit.
    for (genvar b = 0; b < W; b++) begin : g_bit
        assign oh_o[b] = (pos_i == POSW'(b));
    end

endmodule

// File: rtl/accum_addsub.sv
// Selects the base operand for the chosen function and adds or subtracts
// the sign-extended product. Assumes wrap-around arithmetic.
module accum_addsub
    import accum_pkg::*;
#(
    parameter int W = 64
) (
    input  acc_fn_e        fn_i,
    input  logic [W-1:0]   prod_ext_i,
    input  logic [W-1:0]   acc_q_i,
    input  logic [W-1:0]   chain_i,
    input  logic [W-1:0]   const_i,
    output logic [W-1:0]   sum_o
);

    logic [W-1:0] base;
    logic         sub;

    // Base operand and subtract flag per function.
    always_comb begin
        base = '0;
        sub  = 1'b0;
        unique case (fn_i)
            FN_PRELOAD: base = const_i;
            FN_ACC:     base = acc_q_i;
            FN_DECACC: begin base = acc_q_i; sub = 1'b1; end
            FN_CHAIN:  begin base = chain_i; sub = 1'b1; end
            default:    base = '0;
        endcase
    end

    // Single adder, product negated in two's complement when subtracting.
    always_comb begin
        sum_o = sub ? (base - prod_ext_i) : (base + prod_ext_i);
    end

endmodule

// File: rtl/accum_lane_pack.sv
// Dual-mode bypass: sign-extends each half of the product into its own lane.
// Assumes the sub-product width fits inside one lane.
module accum_lane_pack #(
    parameter int W      = 64,
    parameter int PW     = 54,
    localparam int LANES = 2,
    localparam int LW    = W / LANES,
    localparam int SW    = PW / LANES
) (
    input  logic [PW-1:0] prod_i,
    output logic [W-1:0]  lanes_o
);

    // One sign extension per lane.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign lanes_o[l*LW +: LW] =
            {{(LW-SW){prod_i[l*SW+SW-1]}}, prod_i[l*SW +: SW]};
    end

endmodule

// File: rtl/mac_accum_stage.sv
// Accumulate/chain stage after a fixed-point multiplier.
// Registers a 64-bit result chosen each cycle by {neg, ldc, acc}; the chain
// output is that register. Assumes dual_i is static while en_i is active.
module mac_accum_stage
    import accum_pkg::*;
#(
    parameter int ACC_W  = 64,
    parameter int PROD_W = 54,
    localparam int POS_W = $clog2(ACC_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              clr_i,
    input  logic              dual_i,
    input  logic              neg_i,
    input  logic              ldc_i,
    input  logic              acc_i,
    input  logic [POS_W-1:0]  rnd_pos_i,
    input  logic [PROD_W-1:0] prod_i,
    input  logic [ACC_W-1:0]  chain_i,
    output logic [ACC_W-1:0]  result_o,
    output logic [ACC_W-1:0]  chain_o
);

    localparam int EXT_W = ACC_W - PROD_W;

    acc_fn_e          fn;
    logic [ACC_W-1:0] prod_ext;
    logic [ACC_W-1:0] rnd_const;
    logic [ACC_W-1:0] sum;
    logic [ACC_W-1:0] lanes;
    logic [ACC_W-1:0] acc_q;

    // Sign extension of the full product.
    assign prod_ext = {{EXT_W{prod_i[PROD_W-1]}}, prod_i};

    accum_ctrl_decode u_dec (
        .neg_i (neg_i),
        .ldc_i (ldc_i),
        .acc_i (acc_i),
        .fn_o  (fn)
    );

    accum_onehot #(.W(ACC_W)) u_rnd (
        .pos_i (rnd_pos_i),
        .oh_o  (rnd_const)
    );

    accum_addsub #(.W(ACC_W)) u_add (
        .fn_i       (fn),
        .prod_ext_i (prod_ext),
        .acc_q_i    (acc_q),
        .chain_i    (chain_i),
        .const_i    (rnd_const),
        .sum_o      (sum)
    );

    accum_lane_pack #(.W(ACC_W), .PW(PROD_W)) u_lanes (
        .prod_i  (prod_i),
        .lanes_o (lanes)
    );

    // Result register: reset and clear first, then enable, then mode select.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i)
            acc_q <= '0;
        else if (en_i)
            acc_q <= dual_i ? lanes : sum;
    end

    assign result_o = acc_q;
    assign chain_o  = acc_q;

endmodule

// File: rtl/accum_stage_chk.sv
// Property checker for mac_accum_stage, attached by bind below.
// Assumes the same parameters as the bound instance.
module accum_stage_chk #(
    parameter int ACC_W  = 64,
    parameter int PROD_W = 54,
    localparam int POS_W = $clog2(ACC_W)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en_i,
    input logic              clr_i,
    input logic              dual_i,
    input logic              neg_i,
    input logic              ldc_i,
    input logic              acc_i,
    input logic [POS_W-1:0]  rnd_pos_i,
    input logic [PROD_W-1:0] prod_i,
    input logic [ACC_W-1:0]  chain_i,
    input logic [ACC_W-1:0]  result_o,
    input logic [ACC_W-1:0]  chain_o
);

    localparam int LW = ACC_W / 2;
    localparam int SW = PROD_W / 2;

    logic [ACC_W-1:0] p_sx;
    logic [ACC_W-1:0] bitc;
    logic [ACC_W-1:0] dual_exp;
    logic             live;
    logic [2:0]       code;

    // Reference operands formed from the ports.
    assign p_sx     = ACC_W'($signed(prod_i));
    assign bitc     = {{(ACC_W-1){1'b0}}, 1'b1} << rnd_pos_i;
    assign dual_exp = {LW'($signed(prod_i[2*SW-1:SW])), LW'($signed(prod_i[SW-1:0]))};
    assign live     = rst_n && en_i && !clr_i && !dual_i;
    assign code     = {neg_i, ldc_i, acc_i};

    assert_reset_zero_R1: assert property (@(posedge clk)
        !rst_n |=> (result_o == '0 && chain_o == '0));

    assert_zeroing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (live && code == 3'b000) |=> result_o == $past(p_sx));

    assert_preload_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (live && code == 3'b010) |=> result_o == $past(p_sx) + $past(bitc));

    assert_accumulate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (live && acc_i && !neg_i) |=> result_o == $past(result_o) + $past(p_sx));

    assert_decimate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (live && acc_i && neg_i) |=> result_o == $past(result_o) - $past(p_sx));

    assert_chain_sub_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (live && code == 3'b100) |=> result_o == $past(chain_i) - $past(p_sx));

    assert_bad_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (live && code == 3'b110) |=> result_o == $past(p_sx));

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !clr_i) |=> $stable(result_o));

    assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> result_o == '0);

    assert_dual_lanes_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !clr_i && dual_i) |=> result_o == $past(dual_exp));

    cover_bad_code_R7: cover property (@(posedge clk) disable iff (!rst_n)
        live && code == 3'b110);

endmodule

bind mac_accum_stage accum_stage_chk #(.ACC_W(ACC_W), .PROD_W(PROD_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (en_i),
    .clr_i     (clr_i),
    .dual_i    (dual_i),
    .neg_i     (neg_i),
    .ldc_i     (ldc_i),
    .acc_i     (acc_i),
    .rnd_pos_i (rnd_pos_i),
    .prod_i    (prod_i),
    .chain_i   (chain_i),
    .result_o  (result_o),
    .chain_o   (chain_o)
);

// File: tb/tb_mac_accum_stage.sv
// Bench for mac_accum_stage: behavioural reference updated each clock,
// outputs compared one edge after every stimulus.
module tb_mac_accum_stage;

    logic        clk = 1'b0;
    logic        rst_n, en_i, clr_i, dual_i, neg_i, ldc_i, acc_i;
    logic [5:0]  rnd_pos_i;
    logic [53:0] prod_i;
    logic [63:0] chain_i, result_o, chain_o;

    int checks   = 0;
    int failures = 0;
    logic [63:0] model = '0;

    always #2.5 clk = ~clk;

    mac_accum_stage dut (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .clr_i(clr_i), .dual_i(dual_i),
        .neg_i(neg_i), .ldc_i(ldc_i), .acc_i(acc_i), .rnd_pos_i(rnd_pos_i),
        .prod_i(prod_i), .chain_i(chain_i), .result_o(result_o), .chain_o(chain_o)
    );

    // Next value of the result from the requirements.
    function automatic logic [63:0] ref_next(logic r, logic e, logic c, logic d,
            logic [2:0] code, logic [5:0] pos, logic [53:0] p, logic [63:0] ch,
            logic [63:0] prev);
        longint sp = longint'($signed(p));
        logic [63:0] pv = 64'(sp);
        if (!r || c) return 64'd0;
        if (!e) return prev;
        if (d) return {32'($signed(p[53:27])), 32'($signed(p[26:0]))};
        if (code[0] && !code[2]) return prev + pv;
        if (code[0] && code[2])  return prev - pv;
        if (code == 3'b010) return pv + (64'd1 << pos);
        if (code == 3'b100) return ch - pv;
        return pv;
    endfunction

    task automatic step(input string req, input logic r, input logic e,
            input logic c, input logic d, input logic [2:0] code,
            input logic [5:0] pos, input logic [53:0] p, input logic [63:0] ch);
        @(negedge clk);
        rst_n = r; en_i = e; clr_i = c; dual_i = d;
        {neg_i, ldc_i, acc_i} = code;
        rnd_pos_i = pos; prod_i = p; chain_i = ch;
        model = ref_next(r, e, c, d, code, pos, p, ch, model);
        @(posedge clk);
        #1;
        checks++;
        if (result_o !== model) begin
            failures++;
            $display("FAIL %s result_o actual=%h expected=%h", req, result_o, model);
        end
        checks++;
        if (chain_o !== model) begin
            failures++;
            $display("FAIL R11 (%s) chain_o actual=%h expected=%h", req, chain_o, model);
        end
    endtask

    function automatic logic [53:0] pr(longint v);
        return v[53:0];
    endfunction

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R1: reset state
        step("R1", 0, 1, 0, 0, 3'b001, 0, pr(5), 64'd9);
        step("R1", 0, 1, 0, 0, 3'b000, 0, pr(7), 64'd0);
        // R2: zeroing discards the old value
        step("R2", 1, 1, 0, 0, 3'b000, 0, pr(12345), 64'd77);
        step("R2", 1, 1, 0, 0, 3'b000, 0, pr(-7), 64'd77);
        // R3: rounding bit at low, middle and top positions
        step("R3", 1, 1, 0, 0, 3'b010, 0, pr(100), 64'd0);
        step("R3", 1, 1, 0, 0, 3'b010, 15, pr(-3), 64'd0);
        step("R3", 1, 1, 0, 0, 3'b010, 63, pr(0), 64'd0);
        // R4: running sum, ldc toggled has no effect
        step("R4", 1, 1, 0, 0, 3'b000, 0, pr(10), 64'd0);
        step("R4", 1, 1, 0, 0, 3'b001, 5, pr(20), 64'd0);
        step("R4", 1, 1, 0, 0, 3'b011, 9, pr(-50), 64'd0);
        step("R4", 1, 1, 0, 0, 3'b001, 0, pr(64'h1F_FFFF_FFFF_FFFF), 64'd0);
        // R5: running difference, ldc toggled
        step("R5", 1, 1, 0, 0, 3'b101, 0, pr(1000), 64'd0);
        step("R5", 1, 1, 0, 0, 3'b111, 3, pr(-2000), 64'd0);
        // R6: chain minus product
        step("R6", 1, 1, 0, 0, 3'b100, 0, pr(33), 64'h0123_4567_89AB_CDEF);
        step("R6", 1, 1, 0, 0, 3'b100, 0, pr(-33), 64'd5);
        // R7: undefined code behaves as zeroing
        step("R7", 1, 1, 0, 0, 3'b110, 4, pr(-99), 64'hFFFF);
        // R8: wrap at the 2^63 boundary both ways
        step("R8", 1, 1, 0, 0, 3'b100, 0, pr(1), 64'h8000_0000_0000_0000);
        step("R8", 1, 1, 0, 0, 3'b001, 0, pr(1), 64'd0);
        step("R8", 1, 1, 0, 0, 3'b101, 0, pr(1), 64'd0);
        // R9: hold with enable low, clear overrides enable
        step("R9", 1, 0, 0, 0, 3'b001, 0, pr(555), 64'd1);
        step("R9", 1, 0, 0, 0, 3'b100, 0, pr(-1), 64'd2);
        step("R9", 1, 1, 0, 0, 3'b000, 0, pr(42), 64'd0);
        step("R9", 1, 0, 1, 0, 3'b001, 0, pr(42), 64'd0);
        step("R9", 1, 1, 0, 0, 3'b000, 0, pr(42), 64'd0);
        step("R9", 1, 1, 1, 0, 3'b001, 0, pr(42), 64'd0);
        // R10: dual lanes ignore controls and chain
        step("R10", 1, 1, 0, 1, 3'b001, 7, {27'h4000001, 27'h0000123}, 64'hDEAD);
        step("R10", 1, 1, 0, 1, 3'b100, 7, {27'h0000002, 27'h7FFFFFF}, 64'hBEEF);
        step("R10", 1, 1, 0, 1, 3'b010, 7, {27'h3FFFFFF, 27'h4000000}, 64'h1);
        // R1: mid-run reset
        step("R1", 1, 1, 0, 0, 3'b000, 0, pr(-8), 64'd0);
        step("R1", 0, 1, 0, 0, 3'b001, 0, pr(-8), 64'd0);
        step("R2", 1, 1, 0, 0, 3'b000, 0, pr(1), 64'd0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule